// File: doc/BRIEF.md
# Calibration Table Interpolator

This block turns an unsigned raw sensor code into a signed temperature in millidegrees Celsius. It uses a piecewise-linear calibration curve stored in a small internal table of (code, temperature) pairs. The table is filled through a simple write port. The number of valid entries is set by an input, so one instance can serve curves of different lengths. Temperatures normally run from -40000 to 125000 in steps of 5000.

A conversion starts when `req_valid` is seen while the block is idle. The block reads the first two entries to learn whether codes rise or fall with temperature. It then tests the two ends of the curve and clamps inputs that lie outside it. If the input is inside, the block walks the table one entry per cycle from the low end. An exact hit returns the stored temperature. An input that falls strictly between two entries is interpolated, using a bit-serial restoring divider whose quotient is truncated toward zero. `busy` covers the whole operation, and the answer is presented for one cycle with `res_valid`.

Top module: `cal_interp`

## Requirements
- R1: After reset, `busy` and `res_valid` are both low.
- R2: A request is taken only in a cycle where `busy` is low. `req_valid` raised while `busy` is high has no effect: no extra result is produced, and the pending result is unchanged.
- R3: `busy` rises in the cycle after a request is taken. It stays high through the single cycle in which `res_valid` is high, and both are low in the following cycle.
- R4: The table is treated as falling when code[0] > code[1], and as rising otherwise. Search and clamping follow that direction.
- R5: Rising table: an input <= code[0] returns temp[0], and an input >= code[N-1] returns temp[N-1].
- R6: Falling table: an input >= code[0] returns temp[0], and an input <= code[N-1] returns temp[N-1].
- R7: An input equal to the code of an interior entry returns that entry's temperature exactly.
- R8: Any other input lies strictly between adjacent entries k-1 and k. It returns temp[k-1] + ((temp[k-1]-temp[k])*(in-code[k-1])) / (code[k-1]-code[k]), with signed division truncated toward zero.
- R9: N is taken from `tbl_count` (2 to DEPTH). Entries at index N and above do not affect the result, and entry N-1 acts as the end of the curve.
- R10: On a clock edge with `tbl_wr_en` high, entry `tbl_wr_idx` takes `tbl_wr_code` and `tbl_wr_temp`. Later conversions use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_idx | input | IDX_W (6) | Entry index to write |
| tbl_wr_code | input | CODE_W (12) | Raw code for the entry |
| tbl_wr_temp | input | TEMP_W (32) | Signed temperature for the entry, in millidegrees |
| tbl_count | input | CNT_W (6) | Number of valid entries N |
| req_valid | input | 1 | Conversion request |
| req_code | input | CODE_W (12) | Raw code to convert |
| busy | output | 1 | Conversion in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_temp | output | TEMP_W (32) | Signed result in millidegrees |

## Verification
The bound checker covers the handshake on every cycle:
- a taken request raises `busy`;
- `busy` cannot drop before the result appears;
- `res_valid` is a single-cycle pulse inside `busy`;
- the block is idle in the cycle after the result.

The numeric behaviour can only be shown by the bench's scenarios, checked against a reference model of the table search:
- direction detection;
- clamping at both ends of rising and falling curves;
- exact hits;
- interpolation with negative operands and truncation;
- a shortened entry count;
- a rewritten entry;
- requests dropped while busy.

// File: rtl/cal_interp_pkg.sv
package cal_interp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_LAST,
    ST_SCAN,
    ST_DIV,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/cal_tbl.sv
// Calibration entry storage: one write port, two combinational read ports.
module cal_tbl #(
  parameter int DEPTH  = 34,
  parameter int CODE_W = 12,
  parameter int TEMP_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [CODE_W-1:0]        wr_code,
  input  logic signed [TEMP_W-1:0] wr_temp,
  input  logic [IDX_W-1:0]         a_idx,
  output logic [CODE_W-1:0]        a_code,
  output logic signed [TEMP_W-1:0] a_temp,
  input  logic [IDX_W-1:0]         b_idx,
  output logic [CODE_W-1:0]        b_code,
  output logic signed [TEMP_W-1:0] b_temp
);
  logic [CODE_W-1:0]        code_mem [DEPTH];
  logic signed [TEMP_W-1:0] temp_mem [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (hit) begin
        code_mem[k] <= wr_code;
        temp_mem[k] <= wr_temp;
      end
    end
  end

  assign a_code = code_mem[a_idx];
  assign a_temp = temp_mem[a_idx];
  assign b_code = code_mem[b_idx];
  assign b_temp = temp_mem[b_idx];
endmodule

// File: rtl/cal_div.sv
// Unsigned restoring divider, one quotient bit per cycle.
module cal_div #(
  parameter int NUM_W = 46,
  parameter int DEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc_q, acc_d;
  logic [DEN_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d, done_q, done_d;
  logic [DEN_W:0]   rem_sh, rem_sub;
  logic             ge;

  always_comb begin
    rem_sh  = {rem_q, acc_q[NUM_W-1]};
    ge      = rem_sh >= {1'b0, den_q};
    rem_sub = rem_sh - {1'b0, den_q};
    acc_d   = acc_q;
    rem_d   = rem_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    done_d  = 1'b0;
    if (start) begin
      acc_d = num;
      rem_d = '0;
      den_d = den;
      cnt_d = CNT_W'(NUM_W);
      run_d = 1'b1;
    end else if (run_q) begin
      acc_d = {acc_q[NUM_W-2:0], ge};
      rem_d = ge ? DEN_W'(rem_sub) : DEN_W'(rem_sh);
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quo  = acc_q;
endmodule

// File: rtl/cal_interp.sv
module cal_interp #(
  parameter int DEPTH  = 34,
  parameter int CODE_W = 12,
  parameter int TEMP_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tbl_wr_en,
  input  logic [IDX_W-1:0]         tbl_wr_idx,
  input  logic [CODE_W-1:0]        tbl_wr_code,
  input  logic signed [TEMP_W-1:0] tbl_wr_temp,
  input  logic [CNT_W-1:0]         tbl_count,
  input  logic                     req_valid,
  input  logic [CODE_W-1:0]        req_code,
  output logic                     busy,
  output logic                     res_valid,
  output logic signed [TEMP_W-1:0] res_temp
);
  import cal_interp_pkg::*;

  localparam int PROD_W = TEMP_W + CODE_W + 2;
  localparam int DEN_W  = CODE_W + 1;

  cal_state_e st_q, st_d;
  logic [IDX_W-1:0]         idx_q, idx_d, a_idx, b_idx, last_idx;
  logic [CODE_W-1:0]        code_q, code_d, a_code, b_code;
  logic signed [TEMP_W-1:0] a_temp, b_temp, base_q, base_d, res_q, res_d;
  logic                     fall_q, fall_d, neg_q, neg_d;
  logic signed [TEMP_W:0]   d_temp;
  logic signed [CODE_W:0]   d_in, d_ent;
  logic signed [PROD_W-1:0] prod;
  logic [PROD_W-1:0]        prod_mag, quo;
  logic [DEN_W-1:0]         den_mag;
  logic signed [PROD_W-1:0] quo_s;
  logic                     div_start, div_done;

  cal_tbl #(.DEPTH(DEPTH), .CODE_W(CODE_W), .TEMP_W(TEMP_W)) i_tbl (
    .clk(clk), .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_code(tbl_wr_code),
    .wr_temp(tbl_wr_temp), .a_idx(a_idx), .a_code(a_code), .a_temp(a_temp),
    .b_idx(b_idx), .b_code(b_code), .b_temp(b_temp)
  );

  cal_div #(.NUM_W(PROD_W), .DEN_W(DEN_W)) i_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(prod_mag),
    .den(den_mag), .done(div_done), .quo(quo)
  );

  // Interpolation operands between the entries on ports a (k-1) and b (k).
  assign last_idx = IDX_W'(tbl_count - CNT_W'(1));
  assign d_temp   = {a_temp[TEMP_W-1], a_temp} - {b_temp[TEMP_W-1], b_temp};
  assign d_in     = {1'b0, code_q} - {1'b0, a_code};
  assign d_ent    = {1'b0, a_code} - {1'b0, b_code};
  assign prod     = d_temp * d_in;
  assign prod_mag = prod[PROD_W-1] ? -prod : prod;
  assign den_mag  = d_ent[CODE_W] ? -d_ent : d_ent;
  assign quo_s    = neg_q ? -quo : quo;

  always_comb begin
    a_idx = '0;
    b_idx = IDX_W'(1);
    case (st_q)
      ST_LAST: a_idx = last_idx;
      ST_SCAN: begin
        a_idx = idx_q - IDX_W'(1);
        b_idx = idx_q;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    code_d    = code_q;
    fall_d    = fall_q;
    base_d    = base_q;
    neg_d     = neg_q;
    res_d     = res_q;
    div_start = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        code_d = req_code;
        st_d   = ST_PREP;
      end
      ST_PREP: begin
        fall_d = a_code > b_code;
        if (fall_d ? (code_q >= a_code) : (code_q <= a_code)) begin
          res_d = a_temp;
          st_d  = ST_DONE;
        end else begin
          st_d = ST_LAST;
        end
      end
      ST_LAST: begin
        if (fall_q ? (code_q <= a_code) : (code_q >= a_code)) begin
          res_d = a_temp;
          st_d  = ST_DONE;
        end else begin
          idx_d = IDX_W'(1);
          st_d  = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (code_q == b_code) begin
          res_d = b_temp;
          st_d  = ST_DONE;
        end else if (fall_q ? (code_q > b_code) : (code_q < b_code)) begin
          div_start = 1'b1;
          base_d    = a_temp;
          neg_d     = prod[PROD_W-1] ^ d_ent[CODE_W];
          st_d      = ST_DIV;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_DIV: if (div_done) begin
        res_d = base_q + TEMP_W'(quo_s);
        st_d  = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      code_q <= '0;
      fall_q <= 1'b0;
      base_q <= '0;
      neg_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      code_q <= code_d;
      fall_q <= fall_d;
      base_q <= base_d;
      neg_q  <= neg_d;
      res_q  <= res_d;
    end
  end

  assign busy      = st_q != ST_IDLE;
  assign res_valid = st_q == ST_DONE;
  assign res_temp  = res_q;
endmodule

// File: rtl/cal_interp_chk.sv
module cal_interp_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic res_valid
);
  // R2
  req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  // R3
  result_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

  // R3
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R3
  idle_after_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !busy);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !res_valid) |=> busy);
endmodule

bind cal_interp cal_interp_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .busy(busy), .res_valid(res_valid)
);

// File: tb/test_cal_interp.sv
module test_cal_interp;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 34;

  typedef struct {
    int    exp;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr_en = 1'b0;
  logic [5:0]  tbl_wr_idx = '0;
  logic [11:0] tbl_wr_code = '0;
  logic signed [31:0] tbl_wr_temp = '0;
  logic [5:0]  tbl_count = 6'd34;
  logic        req_valid = 1'b0;
  logic [11:0] req_code = '0;
  logic        busy, res_valid;
  logic signed [31:0] res_temp;

  int    checks = 0;
  int    fails = 0;
  int    code_t [DEPTH];
  int    temp_t [DEPTH];
  int    n_ent = DEPTH;
  item_t sb [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_interp i_cal_interp (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_code(tbl_wr_code), .tbl_wr_temp(tbl_wr_temp), .tbl_count(tbl_count),
    .req_valid(req_valid), .req_code(req_code), .busy(busy),
    .res_valid(res_valid), .res_temp(res_temp)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int c);
    bit     fall;
    int     k;
    longint num, den;
    fall = code_t[0] > code_t[1];
    if (fall ? c >= code_t[0] : c <= code_t[0]) return temp_t[0];
    if (fall ? c <= code_t[n_ent-1] : c >= code_t[n_ent-1]) return temp_t[n_ent-1];
    for (k = 1; k < n_ent; k++) begin
      if (c == code_t[k]) return temp_t[k];
      if (fall ? c > code_t[k] : c < code_t[k]) break;
    end
    num = longint'(temp_t[k-1] - temp_t[k]) * longint'(c - code_t[k-1]);
    den = longint'(code_t[k-1] - code_t[k]);
    return temp_t[k-1] + int'(num / den);
  endfunction

  task automatic write_entry(input int k, input int c, input int t);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = 6'(k); tbl_wr_code = 12'(c); tbl_wr_temp = t;
    code_t[k] = c; temp_t[k] = t;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
  endtask

  task automatic load(input bit falling);
    wait_idle();
    for (int k = 0; k < DEPTH; k++)
      write_entry(k, falling ? 3800 - 11*k - (k%2) : 400 + 9*k + (k%3), -40000 + 5000*k);
  endtask

  task automatic convert(input int c, input string tag);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.exp = model(c); it.tag = tag;
    sb.push_back(it);
    req_valid = 1'b1; req_code = 12'(c);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  bit prev_rv = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rv) check(!res_valid && !busy, "R3 idle after result", {res_valid, busy}, 0);
      if (res_valid) begin
        check(busy, "R3 busy with result", busy, 1);
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected result", res_temp, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(res_temp == it.exp, it.tag, res_temp, it.exp);
        end
      end
      prev_rv = res_valid;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !res_valid, "R1 reset state", {busy, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !res_valid, "R1 after release", {busy, res_valid}, 0);

    // Rising curve
    load(1'b0);
    convert(100, "R5 rising below first");
    convert(code_t[0], "R5 rising equal first");
    convert(4000, "R5 rising above last");
    convert(code_t[33], "R5 rising equal last");
    convert(code_t[10], "R7 rising exact interior");
    convert(code_t[0] + 1, "R8 rising interp negative");
    convert(code_t[5] + 3, "R8 rising interp low");
    convert(code_t[20] + 5, "R8 rising interp high");
    convert(code_t[32] + 4, "R8 rising interp top span");

    // R2: requests while busy are dropped
    wait_idle();
    convert(code_t[12] + 2, "R2 first request kept");
    req_valid = 1'b1; req_code = 12'(code_t[30]);
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    check(sb.size() == 0 && !busy, "R2 no extra result", sb.size(), 0);

    // R9: shortened curve
    wait_idle();
    tbl_count = 6'd20; n_ent = 20;
    convert(code_t[25], "R9 clamp at shortened end");
    convert(code_t[18] + 4, "R9 interp last span");
    convert(code_t[19], "R9 equal new last");
    wait_idle();
    tbl_count = 6'd34; n_ent = 34;

    // R10: rewrite an entry
    write_entry(7, code_t[7], 12345);
    convert(code_t[7], "R10 rewritten entry");
    convert(code_t[7] + 1, "R10 interp from rewritten");

    // Falling curve
    load(1'b1);
    convert(4000, "R6 falling above first");
    convert(code_t[0], "R6 falling equal first");
    convert(100, "R6 falling below last");
    convert(code_t[33], "R6 falling equal last");
    convert(code_t[15], "R4 R7 falling exact interior");
    convert(code_t[0] - 4, "R4 R8 falling interp negative");
    convert(code_t[3] - 4, "R8 falling interp low");
    convert(code_t[30] + 2, "R8 falling interp high");

    wait_idle();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule